// File: doc/BRIEF.md
# Copy/Delete Token Gate

This cell joins a control token stream and a data token stream that run at different rates. Each token is one boolean carried on a dual-rail channel with a four-phase return-to-zero handshake: the sender raises the true rail or the false rail, the receiver raises its acknowledge, the sender lowers the rail, and the receiver lowers the acknowledge. A local clock samples every channel, so the cell is a clocked model of a self-timed cell.

For each control token the cell decides what happens to the data token waiting at its data input. A compile-time mode selects one of two variants. In copy mode, a true control token re-emits the waiting data token and leaves it in place, so one data token can be repeated many times. In delete mode, a true control token throws the waiting data token away and emits nothing. In both modes a false control token moves the data token to the output, as a plain buffer would.

Top module: `tcd_gate`

## Requirements
- R1: While rst_n is low, out_t, out_f, ctl_ack and dat_ack are all low.
- R2: Copy mode, true control token: the cell emits a token equal to the waiting data token and acknowledges the control input. In that firing it does not acknowledge the data input.
- R3: Copy mode: a run of true control tokens emits the same held data value once per control token. The held value is replaced only after a false control token.
- R4: Either mode, false control token: the data token goes to the output unchanged. The control input and the data input are both acknowledged in the same firing.
- R5: Copy mode: the number of output tokens equals the number of control tokens consumed. The number of data tokens consumed equals the number of false control tokens.
- R6: Delete mode, true control token: the cell acknowledges the control and data inputs and emits nothing. This discard may fire while an earlier output token is still waiting for its acknowledge.
- R7: Delete mode: the number of data tokens consumed equals the number of control tokens consumed. The number of output tokens equals the number of false control tokens.
- R8: A firing that emits needs three things: a control token, a data token, and an empty output. While the output is occupied, no emitting firing happens, and the control token stays unacknowledged.
- R9: The control acknowledge rises in the same cycle as the output rail rises, or in the same cycle as the data acknowledge for a discard.
- R10: An output rail stays high until out_ack is seen. The next token is offered only after out_ack has fallen. An input acknowledge stays high while that input still has a rail high.
- R11: out_t and out_f are never high together. An input with both rails high is not taken as a token.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_t | input | 1 | Control channel, true rail |
| ctl_f | input | 1 | Control channel, false rail |
| ctl_ack | output | 1 | Control channel acknowledge |
| dat_t | input | 1 | Data channel, true rail |
| dat_f | input | 1 | Data channel, false rail |
| dat_ack | output | 1 | Data channel acknowledge |
| out_t | output | 1 | Output channel, true rail |
| out_f | output | 1 | Output channel, false rail |
| out_ack | input | 1 | Output channel acknowledge from the consumer |

## Verification
In delete mode, two things can happen together: a discard can fire while an earlier emitted token still sits unacknowledged on the output. The bench provokes this by stalling the output consumer after a false control token and then offering true control tokens. It judges the result from the handshake counts on the inputs and from the held output value. It then releases the stall and compares the full output stream with the stream computed from the control and data sequences. The same stall, applied to the copy variant, shows that the next control token stays unacknowledged until the output empties.

// File: rtl/tcd_pkg.sv
// Shared types for the copy/delete token gate.
package tcd_pkg;

    // Variant selected at elaboration
    typedef enum logic {
        GATE_COPY   = 1'b0,
        GATE_DELETE = 1'b1
    } gate_mode_e;

    // A decoded token seen on an input channel
    typedef struct packed {
        logic vld;   // exactly one rail high and not yet acknowledged
        logic val;   // token value (true rail)
    } tok_s;

    // Output channel phase
    typedef enum logic [1:0] {
        TX_EMPTY = 2'd0,
        TX_HOLD  = 2'd1,
        TX_RTZ   = 2'd2
    } tx_state_e;

endpackage

// File: rtl/tcd_rx_port.sv
// Receive side of one dual-rail four-phase channel.
// Presents a token while exactly one rail is high and the acknowledge is low.
// When 'take' is asserted the acknowledge rises. It falls once both rails are low.
// Assumes the sender obeys the return-to-zero protocol.
module tcd_rx_port (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rail_t,
    input  logic          rail_f,
    input  logic          take,
    output logic          ack,
    output tcd_pkg::tok_s tok
);
    logic ack_q;
    logic rails_low;

    assign rails_low = !rail_t && !rail_f;

    // Acknowledge register: set on consume, clear on return to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else if (take) begin
            ack_q <= 1'b1;
        end else if (ack_q && rails_low) begin
            ack_q <= 1'b0;
        end
    end

    // Token decode; two high rails is not a token
    always_comb begin
        tok.vld = (rail_t ^ rail_f) && !ack_q;
        tok.val = rail_t;
    end

    assign ack = ack_q;
endmodule

// File: rtl/tcd_tx_port.sv
// Send side of one dual-rail four-phase channel.
// From the empty state, 'emit' drives one rail high until the consumer acknowledges.
// The rails then return to zero, and the port waits for the acknowledge to fall
// before it reports empty again.
module tcd_tx_port (
    input  logic clk,
    input  logic rst_n,
    input  logic emit,
    input  logic emit_val,
    input  logic ack_in,
    output logic rail_t,
    output logic rail_f,
    output logic empty
);
    import tcd_pkg::*;

    tx_state_e st_q;
    logic      val_q;

    // Handshake phase and held value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= TX_EMPTY;
            val_q <= 1'b0;
        end else begin
            unique case (st_q)
                TX_EMPTY: if (emit) begin
                    st_q  <= TX_HOLD;
                    val_q <= emit_val;
                end
                TX_HOLD:  if (ack_in)  st_q <= TX_RTZ;
                TX_RTZ:   if (!ack_in) st_q <= TX_EMPTY;
                default:  st_q <= TX_EMPTY;
            endcase
        end
    end

    // Rails are driven only while holding a token
    always_comb begin
        rail_t = (st_q == TX_HOLD) &&  val_q;
        rail_f = (st_q == TX_HOLD) && !val_q;
        empty  = (st_q == TX_EMPTY);
    end
endmodule

// File: rtl/tcd_fire_ctrl.sv
// Firing decision for the copy/delete gate.
// Needs a control token and a data token. An emitting firing also needs an empty output.
// A false control token always passes the data. What a true control token does
// depends on MODE: copy re-emits without consuming, delete consumes silently.
module tcd_fire_ctrl #(
    parameter tcd_pkg::gate_mode_e MODE = tcd_pkg::GATE_COPY
) (
    input  tcd_pkg::tok_s ctl,
    input  tcd_pkg::tok_s dat,
    input  logic          out_empty,
    output logic          take_ctl,
    output logic          take_dat,
    output logic          emit,
    output logic          emit_val
);
    logic both_vld;
    logic pass_fire;
    logic true_fire;
    logic true_take_dat;
    logic true_emit;

    assign both_vld  = ctl.vld && dat.vld;
    assign pass_fire = both_vld && !ctl.val && out_empty;

    // Variant for a true control token
    generate
        if (MODE == tcd_pkg::GATE_COPY) begin : g_copy
            assign true_fire     = both_vld && ctl.val && out_empty;
            assign true_take_dat = 1'b0;
            assign true_emit     = true_fire;
        end else begin : g_delete
            assign true_fire     = both_vld && ctl.val;
            assign true_take_dat = true_fire;
            assign true_emit     = 1'b0;
        end
    endgenerate

    // Merge the two control outcomes
    always_comb begin
        take_ctl = pass_fire || true_fire;
        take_dat = pass_fire || true_take_dat;
        emit     = pass_fire || true_emit;
        emit_val = dat.val;
    end
endmodule

// File: rtl/tcd_gate.sv
// Copy/delete token gate: a control stream decides the fate of each waiting data token.
// All three channels are dual-rail four-phase, sampled on clk.
// Assumes input rails change away from the rising edge of clk.
module tcd_gate #(
    parameter tcd_pkg::gate_mode_e MODE = tcd_pkg::GATE_COPY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_t,
    input  logic ctl_f,
    output logic ctl_ack,
    input  logic dat_t,
    input  logic dat_f,
    output logic dat_ack,
    output logic out_t,
    output logic out_f,
    input  logic out_ack
);
    import tcd_pkg::*;

    localparam int NUM_IN = 2;
    localparam int CTL_IX = 0;
    localparam int DAT_IX = 1;

    logic [NUM_IN-1:0] in_t, in_f, in_take, in_ack;
    tok_s              in_tok [NUM_IN];
    logic              out_empty, emit, emit_val;

    assign in_t = {dat_t, ctl_t};
    assign in_f = {dat_f, ctl_f};

    // One receiver per input channel
    generate
        for (genvar g = 0; g < NUM_IN; g++) begin : g_rx
            tcd_rx_port u_rx (
                .clk    (clk),
                .rst_n  (rst_n),
                .rail_t (in_t[g]),
                .rail_f (in_f[g]),
                .take   (in_take[g]),
                .ack    (in_ack[g]),
                .tok    (in_tok[g])
            );
        end
    endgenerate

    tcd_fire_ctrl #(.MODE(MODE)) u_fire (
        .ctl       (in_tok[CTL_IX]),
        .dat       (in_tok[DAT_IX]),
        .out_empty (out_empty),
        .take_ctl  (in_take[CTL_IX]),
        .take_dat  (in_take[DAT_IX]),
        .emit      (emit),
        .emit_val  (emit_val)
    );

    tcd_tx_port u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .emit     (emit),
        .emit_val (emit_val),
        .ack_in   (out_ack),
        .rail_t   (out_t),
        .rail_f   (out_f),
        .empty    (out_empty)
    );

    assign ctl_ack = in_ack[CTL_IX];
    assign dat_ack = in_ack[DAT_IX];
endmodule

// File: rtl/tcd_gate_chk.sv
// Protocol and firing checks for tcd_gate, attached by bind.
module tcd_gate_chk #(
    parameter tcd_pkg::gate_mode_e MODE = tcd_pkg::GATE_COPY
) (
    input logic clk,
    input logic rst_n,
    input logic ctl_t,
    input logic ctl_f,
    input logic ctl_ack,
    input logic dat_t,
    input logic dat_f,
    input logic dat_ack,
    input logic out_t,
    input logic out_f,
    input logic out_ack
);
    // R11
    out_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_t && out_f));

    // R9
    emit_with_ctl_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_t || out_f) |-> $rose(ctl_ack));

    // R4
    false_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctl_ack) && $past(ctl_f)) |-> ($rose(dat_ack) && $rose(out_t || out_f)));

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_t || out_f) && !out_ack) |=> (out_t == $past(out_t)) && (out_f == $past(out_f)));

    // R10
    ctl_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_ack && (ctl_t || ctl_f)) |=> ctl_ack);

    // R10
    dat_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_ack && (dat_t || dat_f)) |=> dat_ack);

    generate
        if (MODE == tcd_pkg::GATE_COPY) begin : g_copy_chk
            // R2
            copy_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(ctl_ack) && $past(ctl_t)) |-> (!$rose(dat_ack) && $rose(out_t || out_f)));
        end else begin : g_del_chk
            // R6
            delete_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(ctl_ack) && $past(ctl_t)) |-> ($rose(dat_ack) && !$rose(out_t || out_f)));
        end
    endgenerate
endmodule

bind tcd_gate tcd_gate_chk #(.MODE(MODE)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_t   (ctl_t),
    .ctl_f   (ctl_f),
    .ctl_ack (ctl_ack),
    .dat_t   (dat_t),
    .dat_f   (dat_f),
    .dat_ack (dat_ack),
    .out_t   (out_t),
    .out_f   (out_f),
    .out_ack (out_ack)
);

// File: tb/tb_tcd_gate.sv
// Token source: sends bits[0..n-1] over a four-phase dual-rail channel.
module tb_tok_src #(parameter int MAXN = 64) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [MAXN-1:0] bits,
    input  int              n,
    input  int              max_gap,
    input  logic            ack,
    output logic            rail_t,
    output logic            rail_f,
    output int              done_cnt
);
    int st;
    int gap;
    always @(negedge clk) begin
        if (!rst_n) begin
            rail_t <= 0; rail_f <= 0; done_cnt <= 0; st <= 0; gap <= 0;
        end else begin
            case (st)
                0: if (done_cnt < n) begin
                    if (gap > 0) gap <= gap - 1;
                    else begin
                        rail_t <= bits[done_cnt];
                        rail_f <= !bits[done_cnt];
                        st <= 1;
                    end
                end
                1: if (ack) begin rail_t <= 0; rail_f <= 0; st <= 2; end
                default: if (!ack) begin
                    done_cnt <= done_cnt + 1;
                    gap <= $urandom_range(max_gap, 0);
                    st <= 0;
                end
            endcase
        end
    end
endmodule

// Token sink: records received values, acknowledges after a random gap unless held.
module tb_tok_sink #(parameter int MAXN = 64) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rail_t,
    input  logic            rail_f,
    input  int              max_gap,
    input  logic            hold,
    output logic            ack,
    output logic [MAXN-1:0] got,
    output int              got_cnt
);
    int gap;
    always @(negedge clk) begin
        if (!rst_n) begin
            ack <= 0; got <= '0; got_cnt <= 0; gap <= 0;
        end else if (!ack) begin
            if ((rail_t || rail_f) && !hold) begin
                if (gap > 0) gap <= gap - 1;
                else begin
                    if (got_cnt < MAXN) got[got_cnt] <= rail_t;
                    got_cnt <= got_cnt + 1;
                    ack <= 1;
                    gap <= $urandom_range(max_gap, 0);
                end
            end
        end else if (!rail_t && !rail_f) begin
            ack <= 0;
        end
    end
endmodule

module tb_tcd_gate;
    localparam int MAXN = 64;

    logic clk = 0;
    logic rst_n = 0;
    always #4 clk = !clk;

    logic [MAXN-1:0] ctl_bits, dat_bits;
    int n_ctl, n_false, gap_max;
    logic hold;

    // copy instance channels (a_) and delete instance channels (b_)
    logic a_ct, a_cf, a_ca, a_dt, a_df, a_da, a_ot, a_of, a_oa;
    logic b_ct, b_cf, b_ca, b_dt, b_df, b_da, b_ot, b_of, b_oa;
    int a_csent, a_dsent, a_got_cnt, b_csent, b_dsent, b_got_cnt;
    logic [MAXN-1:0] a_got, b_got;

    tcd_gate #(.MODE(tcd_pkg::GATE_COPY)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_t(a_ct), .ctl_f(a_cf), .ctl_ack(a_ca),
        .dat_t(a_dt), .dat_f(a_df), .dat_ack(a_da), .out_t(a_ot), .out_f(a_of), .out_ack(a_oa));
    tcd_gate #(.MODE(tcd_pkg::GATE_DELETE)) dut_del (
        .clk(clk), .rst_n(rst_n), .ctl_t(b_ct), .ctl_f(b_cf), .ctl_ack(b_ca),
        .dat_t(b_dt), .dat_f(b_df), .dat_ack(b_da), .out_t(b_ot), .out_f(b_of), .out_ack(b_oa));

    tb_tok_src #(MAXN) a_csrc (.clk(clk), .rst_n(rst_n), .bits(ctl_bits), .n(n_ctl), .max_gap(gap_max),
        .ack(a_ca), .rail_t(a_ct), .rail_f(a_cf), .done_cnt(a_csent));
    tb_tok_src #(MAXN) a_dsrc (.clk(clk), .rst_n(rst_n), .bits(dat_bits), .n(n_false), .max_gap(gap_max),
        .ack(a_da), .rail_t(a_dt), .rail_f(a_df), .done_cnt(a_dsent));
    tb_tok_sink #(MAXN) a_snk (.clk(clk), .rst_n(rst_n), .rail_t(a_ot), .rail_f(a_of), .max_gap(gap_max),
        .hold(hold), .ack(a_oa), .got(a_got), .got_cnt(a_got_cnt));
    tb_tok_src #(MAXN) b_csrc (.clk(clk), .rst_n(rst_n), .bits(ctl_bits), .n(n_ctl), .max_gap(gap_max),
        .ack(b_ca), .rail_t(b_ct), .rail_f(b_cf), .done_cnt(b_csent));
    tb_tok_src #(MAXN) b_dsrc (.clk(clk), .rst_n(rst_n), .bits(dat_bits), .n(n_ctl), .max_gap(gap_max),
        .ack(b_da), .rail_t(b_dt), .rail_f(b_df), .done_cnt(b_dsent));
    tb_tok_sink #(MAXN) b_snk (.clk(clk), .rst_n(rst_n), .rail_t(b_ot), .rail_f(b_of), .max_gap(gap_max),
        .hold(hold), .ack(b_oa), .got(b_got), .got_cnt(b_got_cnt));

    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected copy output: each control token emits the head data token; false pops it
    function automatic logic [MAXN-1:0] exp_copy(logic [MAXN-1:0] c, logic [MAXN-1:0] d, int n);
        logic [MAXN-1:0] o = '0;
        int p = 0;
        for (int i = 0; i < n; i++) begin
            o[i] = d[p];
            if (!c[i]) p++;
        end
        return o;
    endfunction

    // Expected delete output: data i emitted only when control i is false
    function automatic logic [MAXN-1:0] exp_del(logic [MAXN-1:0] c, logic [MAXN-1:0] d, int n);
        logic [MAXN-1:0] o = '0;
        int k = 0;
        for (int i = 0; i < n; i++) begin
            if (!c[i]) begin o[k] = d[i]; k++; end
        end
        return o;
    endfunction

    function automatic int count_false(logic [MAXN-1:0] c, int n);
        int k = 0;
        for (int i = 0; i < n; i++) if (!c[i]) k++;
        return k;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!(a_got_cnt == n_ctl && b_got_cnt == n_false && a_csent == n_ctl &&
                 a_dsent == n_false && b_csent == n_ctl && b_dsent == n_ctl) && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 20000, "R8", t, 0, "run stalled");
        repeat (4) @(negedge clk);
    endtask

    task automatic check_run(input string tag);
        logic [MAXN-1:0] ea, eb;
        ea = exp_copy(ctl_bits, dat_bits, n_ctl);
        eb = exp_del(ctl_bits, dat_bits, n_ctl);
        chk(a_got_cnt == n_ctl, "R5", a_got_cnt, n_ctl, {tag, " copy output count"});
        chk(a_dsent == n_false, "R5", a_dsent, n_false, {tag, " copy data consumed"});
        chk(b_got_cnt == n_false, "R7", b_got_cnt, n_false, {tag, " delete output count"});
        chk(b_dsent == b_csent, "R7", b_dsent, b_csent, {tag, " delete data vs control"});
        for (int i = 0; i < n_ctl; i++)
            chk(a_got[i] == ea[i], "R3", int'(a_got[i]), int'(ea[i]), {tag, " copy value (R2/R4)"});
        for (int i = 0; i < n_false; i++)
            chk(b_got[i] == eb[i], "R6", int'(b_got[i]), int'(eb[i]), {tag, " delete value (R4)"});
    endtask

    task automatic run_case(input logic [MAXN-1:0] c, input logic [MAXN-1:0] d, input int n,
                            input int g, input string tag);
        rst_n = 0;
        ctl_bits = c; dat_bits = d; n_ctl = n; gap_max = g; hold = 0;
        n_false = count_false(c, n);
        do_reset();
        wait_done();
        check_run(tag);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [MAXN-1:0] c, d;
        int n;
        void'($urandom(1234));
        ctl_bits = '0; dat_bits = '0; n_ctl = 0; n_false = 0; gap_max = 0; hold = 0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk({a_ot, a_of, a_ca, a_da} == 4'b0, "R1", int'({a_ot, a_of, a_ca, a_da}), 0, "copy reset outputs");
        chk({b_ot, b_of, b_ca, b_da} == 4'b0, "R1", int'({b_ot, b_of, b_ca, b_da}), 0, "delete reset outputs");

        // R3: T,T,T,F on one held data token (ctl bit0 first)
        run_case(64'b0111, 64'b1, 4, 1, "R3 repeat");
        // R4: all false, pure buffer
        run_case(64'b0, 64'hA5, 8, 0, "R4 all false");
        // back-to-back alternation, no gaps
        run_case(64'h0AAA, 64'h5C3, 16, 0, "alternate");

        // R8 and R6: output held while delete discards
        rst_n = 0;
        ctl_bits = 64'b0110; dat_bits = 64'b0101; n_ctl = 4; gap_max = 0; hold = 1;
        n_false = count_false(ctl_bits, 4);
        do_reset();
        repeat (60) @(negedge clk);
        chk(a_csent == 1, "R8", a_csent, 1, "copy control taken while output full");
        chk(a_ct && !a_ca, "R8", int'(a_ca), 0, "copy second control left pending");
        chk(a_ot && !a_of, "R10", int'({a_ot, a_of}), 2, "copy output held");
        chk(b_csent == 3, "R6", b_csent, 3, "delete discards with output full");
        chk(b_dsent == 3, "R6", b_dsent, 3, "delete data consumed with output full");
        chk(b_ot && !b_of, "R10", int'({b_ot, b_of}), 2, "delete output held");
        hold = 0;
        wait_done();
        check_run("hold");

        // random streams; final control forced false so copy drains
        for (int r = 0; r < 10; r++) begin
            n = $urandom_range(40, 5);
            c = {$urandom(), $urandom()};
            d = {$urandom(), $urandom()};
            c[n-1] = 1'b0;
            run_case(c, d, n, r % 4, "random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule